// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block sends and receives asynchronous serial characters. The transmitter takes one byte through a ready/valid handshake and shifts it out as a frame on `txd`. The frame is a low start bit, the data bits with the least significant bit first, an optional parity bit and one or two high stop bits. The receiver watches `rxd` and finds the start of a character. It samples each bit near its middle and reports the byte for one cycle, together with parity, framing and break flags.

The line rate comes from an integer divisor and an oversampling factor. Each bit lasts `cfg_div` clock periods times 16 in normal mode, or times 8 in fast mode. The character format is set by static configuration inputs: data length, parity style, stop-bit count and a request to hold the line in break. Both directions read the same configuration. It should change only while the block is idle.

Top module: `uart_frame_engine`

## Requirements
- R1: One bit on `txd` lasts exactly `D*16` clock cycles, or `D*8` when `cfg_fast` is 1. `D` is `cfg_div`, and a value of 0 counts as 1.
- R2: A frame starts with one low bit. The data bits follow, least significant first. `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused high bits of `tx_data` are not sent.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_stick`=0 it makes the count of ones in data plus parity even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1). With `cfg_par_stick`=1 the parity bit equals `cfg_par_odd`.
- R4: The frame ends with one high stop bit, or two when `cfg_two_stop` is 1. When nothing is being sent and no break is requested, `txd` stays high.
- R5: `tx_ready` is high only when no frame is in progress and `cfg_brk` is 0. A byte is taken on a clock edge where both `tx_valid` and `tx_ready` are high, and its start bit appears on the next cycle. `tx_busy` is high from the first cycle of the start bit through the last cycle of the last stop bit.
- R6: While `cfg_brk` is 1, a frame in progress is completed first. After that `txd` is held low and no byte is accepted. Clearing `cfg_brk` returns the line to high.
- R7: The receiver passes `rxd` through a two-flop synchroniser. A low pulse that is shorter than half a bit is ignored and produces no report.
- R8: For each received frame, `rx_valid` is high for exactly one cycle. This pulse comes before the first stop bit ends, and `rx_data` then holds the data bits with the unused high bits set to zero.
- R9: `rx_par_err` is set on a report when parity is enabled and the received parity bit differs from the value R3 gives for the received data.
- R10: `rx_frm_err` is set when the first stop bit is sampled low. Only the first stop bit is checked, in both stop modes.
- R11: When every bit of a frame is low (start, data, parity and first stop), the report has `rx_brk`=1, `rx_frm_err`=1 and `rx_data`=0. The receiver then waits for the line to go high before it looks for a new start bit, so a long break gives only one report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Clock cycles per oversampling tick (0 acts as 1) |
| cfg_fast | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| cfg_len | input | 2 | Data length code: 0..3 give 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity, or the stick value |
| cfg_par_stick | input | 1 | Parity bit fixed to cfg_par_odd |
| cfg_two_stop | input | 1 | Send two stop bits |
| cfg_brk | input | 1 | Hold the line low after the current frame |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | A byte can be accepted |
| txd | output | 1 | Serial output |
| tx_busy | output | 1 | A frame is on the line |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_data | output | 8 | Last received data |
| rx_valid | output | 1 | One-cycle report strobe |
| rx_par_err | output | 1 | Parity mismatch on the last report |
| rx_frm_err | output | 1 | First stop bit was low on the last report |
| rx_brk | output | 1 | Whole last frame was low |

## Verification
The hardest cases to reach are the receiver's recovery paths. One is a start pulse that disappears before the half-bit check. The other is a break that lasts longer than a frame, where the receiver must report once and then wait for the line to go high. The bench drives `rxd` one cycle at a time and builds these cases directly: a low pulse a quarter bit long, and a low level held for two full frame lengths. It also sends frames with a corrupted parity bit or stop bit. On the transmit side, break-send is raised while a frame is in the middle of being sent, with `tx_valid` held high. A cycle-accurate model then shows whether the frame finishes, whether the line stays low, and whether the queued byte waits until break-send is cleared.

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_fast,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_par_stick,
  input  logic             cfg_two_stop,
  input  logic             cfg_brk,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  output logic             tx_busy,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_par_err,
  output logic             rx_frm_err,
  output logic             rx_brk
);
  localparam int FW = 12;

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS, R_WAIT} rx_st_t;

  function automatic logic par_of(input logic [7:0] d, input logic [7:0] m,
                                  input logic odd, input logic stick);
    return stick ? odd : ((^(d & m)) ^ odd);
  endfunction

  logic [DIV_W-1:0] div_lim;
  logic [3:0]       os_last, os_half, nd;
  logic [7:0]       dmask;

  assign div_lim = (cfg_div == '0) ? '0 : cfg_div - DIV_W'(1);
  assign os_last = cfg_fast ? 4'd7 : 4'd15;
  assign os_half = cfg_fast ? 4'd3 : 4'd7;
  assign nd      = {2'b00, cfg_len} + 4'd5;
  assign dmask   = 8'hFF >> (2'd3 - cfg_len);

  // transmitter
  logic [FW-1:0]    tx_sh, tx_frame;
  logic [3:0]       tx_left, tx_os, tx_count;
  logic [DIV_W-1:0] tx_pc;
  logic             tx_acc;

  assign tx_busy  = tx_left != 4'd0;
  assign tx_ready = !tx_busy && !cfg_brk;
  assign tx_acc   = tx_valid && tx_ready;
  assign txd      = tx_busy ? tx_sh[0] : !cfg_brk;
  assign tx_count = 4'd2 + nd + {3'b000, cfg_par_en} + {3'b000, cfg_two_stop};

  always_comb begin
    tx_frame    = '1;
    tx_frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < nd) tx_frame[i+1] = tx_data[i];
    if (cfg_par_en)
      tx_frame[nd + 4'd1] = par_of(tx_data, dmask, cfg_par_odd, cfg_par_stick);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh   <= '1;
      tx_left <= '0;
      tx_os   <= '0;
      tx_pc   <= '0;
    end else if (tx_acc) begin
      tx_sh   <= tx_frame;
      tx_left <= tx_count;
      tx_os   <= '0;
      tx_pc   <= '0;
    end else if (tx_busy) begin
      if (tx_pc == div_lim) begin
        tx_pc <= '0;
        if (tx_os == os_last) begin
          tx_os   <= '0;
          tx_sh   <= {1'b1, tx_sh[FW-1:1]};
          tx_left <= tx_left - 4'd1;
        end else begin
          tx_os <= tx_os + 4'd1;
        end
      end else begin
        tx_pc <= tx_pc + DIV_W'(1);
      end
    end
  end

  // receiver
  rx_st_t           rx_st;
  logic             s1, s2;
  logic [DIV_W-1:0] rx_pc;
  logic [3:0]       rx_os, rx_idx, rx_last;
  logic [8:0]       rx_bits;
  logic [7:0]       rx_d;
  logic             rx_tick;

  assign rx_tick = rx_pc == div_lim;
  assign rx_last = nd + {3'b000, cfg_par_en};
  assign rx_d    = rx_bits[7:0] & dmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st      <= R_IDLE;
      rx_pc      <= '0;
      rx_os      <= '0;
      rx_idx     <= '0;
      rx_bits    <= '0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      rx_brk     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rx_st == R_START || rx_st == R_BITS)
        rx_pc <= rx_tick ? '0 : rx_pc + DIV_W'(1);
      case (rx_st)
        R_IDLE: if (!s2) begin
          rx_st <= R_START;
          rx_pc <= '0;
          rx_os <= '0;
        end
        R_START: if (rx_tick) begin
          if (rx_os == os_half) begin
            rx_os  <= '0;
            rx_idx <= '0;
            rx_st  <= s2 ? R_IDLE : R_BITS;
          end else begin
            rx_os <= rx_os + 4'd1;
          end
        end
        R_BITS: if (rx_tick) begin
          if (rx_os == os_last) begin
            rx_os <= '0;
            if (rx_idx == rx_last) begin
              rx_valid   <= 1'b1;
              rx_data    <= rx_d;
              rx_par_err <= cfg_par_en &&
                            (rx_bits[nd] != par_of(rx_d, dmask, cfg_par_odd, cfg_par_stick));
              rx_frm_err <= !s2;
              rx_brk     <= !s2 && (rx_d == 8'h00) && !(cfg_par_en && rx_bits[nd]);
              rx_st      <= s2 ? R_IDLE : R_WAIT;
            end else begin
              rx_bits[rx_idx] <= s2;
              rx_idx          <= rx_idx + 4'd1;
            end
          end else begin
            rx_os <= rx_os + 4'd1;
          end
        end
        default: if (s2) rx_st <= R_IDLE;
      endcase
    end
  end

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  // R4
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(txd));
  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> tx_busy);
  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R11
  brk_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> (rx_frm_err && rx_data == 8'h00));
endmodule

// File: tb/uart_frame_engine_tb.sv
module uart_frame_engine_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd2;
  logic        cfg_fast = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic        cfg_par_stick = 1'b0, cfg_two_stop = 1'b0, cfg_brk = 1'b0;
  logic [1:0]  cfg_len = 2'd3;
  logic [7:0]  tx_data = 8'h00, rx_data;
  logic        tx_valid = 1'b0, tx_ready, txd, tx_busy, rxd = 1'b1;
  logic        rx_valid, rx_par_err, rx_frm_err, rx_brk;

  int checks = 0, errors = 0, acc_cnt = 0, m_cnt = 0;
  bit m_q[$];
  logic [10:0] r_q[$];

  always #10 clk = ~clk;

  uart_frame_engine #(.DIV_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_fast(cfg_fast), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_par_stick(cfg_par_stick),
    .cfg_two_stop(cfg_two_stop), .cfg_brk(cfg_brk), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .tx_busy(tx_busy), .rxd(rxd), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int blen();
    return ((cfg_div == 0) ? 1 : int'(cfg_div)) * (cfg_fast ? 8 : 16);
  endfunction

  function automatic int ndata();
    return 5 + int'(cfg_len);
  endfunction

  function automatic logic [7:0] trim(input logic [7:0] d);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < ndata(); i++) r[i] = d[i];
    return r;
  endfunction

  // R3 parity rule
  function automatic bit pbit(input logic [7:0] d);
    int ones = 0;
    if (cfg_par_stick) return cfg_par_odd;
    for (int i = 0; i < ndata(); i++) ones += int'(d[i]);
    return bit'(ones % 2) ^ cfg_par_odd;
  endfunction

  // transmit reference: R1 R2 R3 R4 R5 R6
  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete();
      m_cnt = 0;
    end else if (m_q.size() > 0) begin
      if (m_cnt == blen() - 1) begin
        void'(m_q.pop_front());
        m_cnt = 0;
      end else m_cnt++;
    end else if (tx_valid && !cfg_brk) begin
      m_q.push_back(1'b0);
      for (int i = 0; i < ndata(); i++) m_q.push_back(tx_data[i]);
      if (cfg_par_en) m_q.push_back(pbit(tx_data));
      m_q.push_back(1'b1);
      if (cfg_two_stop) m_q.push_back(1'b1);
      m_cnt = 0;
      acc_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_txd;
      exp_txd = (m_q.size() > 0) ? m_q[0] : !cfg_brk;
      chk(txd == exp_txd, "R1 R2 R3 R4 R6 txd", int'(txd), int'(exp_txd));
      chk(tx_busy == (m_q.size() > 0), "R5 tx_busy", int'(tx_busy), int'(m_q.size() > 0));
      chk(tx_ready == (m_q.size() == 0 && !cfg_brk), "R5 R6 tx_ready", int'(tx_ready),
          int'(m_q.size() == 0 && !cfg_brk));
      if (rx_valid) begin
        if (r_q.size() == 0) chk(1'b0, "R7 R8 unexpected rx_valid", 1, 0);
        else begin
          logic [10:0] e;
          e = r_q.pop_front();
          chk(rx_data == e[7:0], "R8 rx_data", int'(rx_data), int'(e[7:0]));
          chk(rx_par_err == e[8], "R9 rx_par_err", int'(rx_par_err), int'(e[8]));
          chk(rx_frm_err == e[9], "R10 rx_frm_err", int'(rx_frm_err), int'(e[9]));
          chk(rx_brk == e[10], "R11 rx_brk", int'(rx_brk), int'(e[10]));
        end
      end
    end
  end

  task automatic send_tx(input logic [7:0] d);
    int n = acc_cnt;
    tx_data  = d;
    tx_valid = 1'b1;
    while (acc_cnt == n) @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_drain();
    while (m_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic drive_bit(input bit b);
    rxd = b;
    repeat (blen()) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [7:0] t = trim(d);
    bit p = pbit(t) ^ bad_par;
    r_q.push_back({1'b0, bad_stop, cfg_par_en & bad_par, t});
    drive_bit(1'b0);
    for (int i = 0; i < ndata(); i++) drive_bit(t[i]);
    if (cfg_par_en) drive_bit(p);
    drive_bit(!bad_stop);
    #1;
    chk(r_q.size() == 0, "R8 report before end of stop", r_q.size(), 0);
    if (cfg_two_stop) drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic rx_glitch();
    rxd = 1'b0;
    repeat (blen() / 4) @(negedge clk);
    drive_bit(1'b1);
    drive_bit(1'b1);
    #1;
    chk(r_q.size() == 0, "R7 glitch ignored", r_q.size(), 0);
  endtask

  task automatic rx_break();
    int fb = 2 + ndata() + int'(cfg_par_en);
    r_q.push_back({1'b1, 1'b1, cfg_par_en & pbit(8'h00), 8'h00});
    rxd = 1'b0;
    repeat (2 * fb * blen()) @(negedge clk);
    drive_bit(1'b1);
    drive_bit(1'b1);
    #1;
    chk(r_q.size() == 0, "R11 single break report", r_q.size(), 0);
  endtask

  task automatic run();
    int cdiv[5]  = '{2, 3, 0, 2, 4};
    bit cfst[5]  = '{0, 1, 0, 1, 0};
    int clen[5]  = '{3, 0, 2, 1, 3};
    bit cpen[5]  = '{0, 1, 1, 1, 1};
    bit codd[5]  = '{0, 0, 1, 1, 0};
    bit cstk[5]  = '{0, 0, 0, 1, 1};
    bit c2st[5]  = '{0, 1, 0, 1, 0};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && tx_ready && !tx_busy && !rx_valid, "R4 R5 reset state",
        int'({txd, tx_ready, tx_busy, rx_valid}), 'b1100);
    for (int c = 0; c < 5; c++) begin
      cfg_div = 16'(cdiv[c]); cfg_fast = cfst[c]; cfg_len = 2'(clen[c]);
      cfg_par_en = cpen[c]; cfg_par_odd = codd[c]; cfg_par_stick = cstk[c];
      cfg_two_stop = c2st[c];
      repeat (4) @(negedge clk);
      send_tx(8'hA5);
      send_tx(8'h3C);
      tx_drain();
      send_tx(8'hFF);
      tx_drain();
      send_rx(8'h5A, 1'b0, 1'b0);
      send_rx(8'hC3, 1'b0, 1'b0);
      if (cfg_par_en) send_rx(8'h96, 1'b1, 1'b0);
      send_rx(8'h6D, 1'b0, 1'b1);
      rx_glitch();
      rx_break();
    end
    // R6 break while a frame is running, with a byte waiting
    send_tx(8'h81);
    repeat (blen() * 3) @(negedge clk);
    cfg_brk  = 1'b1;
    tx_data  = 8'h42;
    tx_valid = 1'b1;
    while (m_q.size() > 0) @(negedge clk);
    repeat (blen() * 4) @(negedge clk);
    chk(txd == 1'b0 && acc_cnt > 0, "R6 line held low", int'(txd), 0);
    begin
      int n = acc_cnt;
      cfg_brk = 1'b0;
      while (acc_cnt == n) @(negedge clk);
      tx_valid = 1'b0;
    end
    tx_drain();
  endtask

  initial begin
    bit timeout = 1'b0;
    fork
      run();
      begin
        repeat (190000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule